// File: doc/BRIEF.md
# Calendar Validate and BCD Packer

This block takes a calendar setting in plain binary: a four-digit year, a month counted from 1, and the day, hour, minute and second. The setting arrives on a valid/ready handshake. The block tests the setting for legality. A legal setting is turned into six BCD bytes, which are sent as register writes through a downstream valid/ready port, one byte per field, in a fixed order. An illegal setting is dropped: it produces a one-cycle error pulse and no writes.

A separate combinational path does the reverse conversion. It takes six BCD bytes read back from the timekeeping registers and returns binary fields. On this path the year is counted from 1900 and the month is counted from 0.

The controller is an enumerated state machine with three states:
- `ST_IDLE` raises `in_ready`. It moves to `ST_EMIT` when it accepts a legal setting. It stays in `ST_IDLE` when it accepts an illegal setting.
- `ST_EMIT` presents one write at a time. On each `wr_ready` it moves on to the next field. After the sixth write it moves to `ST_FIN`.
- `ST_FIN` raises `done_pulse` for one cycle and always returns to `ST_IDLE`.

Top module: `cal_pack_top`

## Requirements
- R1: After reset, `in_ready` is 1, and `wr_valid`, `err_pulse` and `done_pulse` are 0.
- R2: The year is accepted only if it lies from 1970 to 2069 inclusive. Any other year is illegal.
- R3: The month must be 1 to 12. The day must be 1 to the month length (31,28,31,30,31,30,31,31,30,31,30,31). February has 29 days in a leap year. A leap year is divisible by 4 and not by 100, or is divisible by 400.
- R4: An hour of 24 or more, a minute of 60 or more, or a second of 60 or more is illegal.
- R5: When an illegal setting is accepted, `err_pulse` is high in that same cycle. No write follows, and `in_ready` stays 1.
- R6: A legal setting produces exactly six writes, in this order of `wr_addr`: year=5, month=4, day=3, hour=2, minute=1, second=0. `wr_data` holds the tens digit in bits [7:4] and the units digit in bits [3:0].
- R7: The stored year is the year minus 2000 when the year is 2000 or later, and the year minus 1900 otherwise.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. `in_ready` is 0 from acceptance until `done_pulse` has ended.
- R9: `done_pulse` is high for exactly one cycle: the cycle after the sixth write handshake. `in_ready` returns to 1 in the next cycle.
- R10: The readback outputs `out_day`, `out_hour`, `out_min` and `out_sec` are the binary values of their BCD inputs (tens times 10 plus units).
- R11: `out_year` is the decoded readback year plus 100 when the decoded value is 69 or less, and the decoded value unchanged otherwise. `out_month` is the decoded month minus 1, taken modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A setting is offered |
| in_ready | output | 1 | The block can accept a setting |
| in_year | input | 12 | Full binary year |
| in_month | input | 4 | Month, 1-based |
| in_day | input | 5 | Day of month |
| in_hour | input | 5 | Hour |
| in_min | input | 6 | Minute |
| in_sec | input | 6 | Second |
| err_pulse | output | 1 | Illegal setting rejected |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Downstream takes the write |
| wr_addr | output | 3 | Register index of the write |
| wr_data | output | 8 | BCD byte of the write |
| done_pulse | output | 1 | All six writes finished |
| rb_year | input | 8 | BCD year read back |
| rb_month | input | 8 | BCD month read back |
| rb_day | input | 8 | BCD day read back |
| rb_hour | input | 8 | BCD hour read back |
| rb_min | input | 8 | BCD minute read back |
| rb_sec | input | 8 | BCD second read back |
| out_year | output | 8 | Years since 1900 |
| out_month | output | 8 | Month, 0-based |
| out_day | output | 8 | Binary day |
| out_hour | output | 8 | Binary hour |
| out_min | output | 8 | Binary minute |
| out_sec | output | 8 | Binary second |

## Verification
The bench targets the following corner cases:

| Corner case | What a faulty design would do |
|---|---|
| Window edges 1969, 1970, 2069 and 2070 | An off-by-one comparison would accept 1969 or 2070, or reject 1970 or 2069. |
| February 29 in 2000, 2024 and 2023 | A wrong leap rule would reject 2000 or accept 2023. |
| Day 31 in a 30-day month | A month-length table out of step would accept it. |
| Minute 60 and hour 24 | A design testing "greater than" instead of "greater or equal" would pass them. |
| Years 1999 and 2000 | A mistake in the century split would write 99 as a wrong BCD byte. |
| Random stalls on `wr_ready` | A design that advances without a handshake would skip or repeat a field. |
| Readback years 69 and 70 | These check the boundary of the +100 adjustment. |
| Readback month 0 | This checks that the decrement wraps to 255. |

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int YEAR_W   = 12;
    localparam int MON_W    = 4;
    localparam int DAY_W    = 5;
    localparam int HOUR_W   = 5;
    localparam int MIN_W    = 6;
    localparam int SEC_W    = 6;
    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 7;
    localparam int NREG     = 6;
    localparam int ADDR_W   = 3;
    localparam int IDX_W    = $clog2(NREG);

    localparam int YEAR_LO    = 1970;
    localparam int YEAR_HI    = 2069;
    localparam int CENT_SPLIT = 2000;
    localparam int CENT_PREV  = 1900;
    localparam int WRAP_LIMIT = 69;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEC  = 3'd0,
        REG_MIN  = 3'd1,
        REG_HOUR = 3'd2,
        REG_DAY  = 3'd3,
        REG_MON  = 3'd4,
        REG_YEAR = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_FIN
    } pk_state_e;

    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] r;
        unique case (m)
            4'd1, 4'd3, 4'd5, 4'd7, 4'd8, 4'd10, 4'd12: r = 5'd31;
            4'd4, 4'd6, 4'd9, 4'd11:                    r = 5'd30;
            4'd2:                                       r = leap ? 5'd29 : 5'd28;
            default:                                    r = 5'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_check.sv
module cal_check
    import cal_pkg::*;
#(
    parameter int YW = YEAR_W
) (
    input  logic [YW-1:0]     year,
    input  logic [MON_W-1:0]  month,
    input  logic [DAY_W-1:0]  day,
    input  logic [HOUR_W-1:0] hour,
    input  logic [MIN_W-1:0]  minute,
    input  logic [SEC_W-1:0]  second,
    output logic              legal,
    output logic [VAL_W-1:0]  yy
);

    logic             leap;
    logic             yr_ok;
    logic             date_ok;
    logic             time_ok;
    logic [DAY_W-1:0] mlen;

    always_comb begin
        leap    = (((year % YW'(4)) == '0) && ((year % YW'(100)) != '0))
                  || ((year % YW'(400)) == '0);
        yr_ok   = (year >= YW'(YEAR_LO)) && (year <= YW'(YEAR_HI));
        mlen    = month_len(month, leap);
        date_ok = (day != '0) && (day <= mlen);
        time_ok = (hour < HOUR_W'(24)) && (minute < MIN_W'(60)) && (second < SEC_W'(60));
        legal   = yr_ok && date_ok && time_ok;
        if (year >= YW'(CENT_SPLIT))
            yy = VAL_W'(year - YW'(CENT_SPLIT));
        else
            yy = VAL_W'(year - YW'(CENT_PREV));
    end

endmodule

// File: rtl/bcd_enc.sv
module bcd_enc
    import cal_pkg::*;
#(
    parameter int VW = VAL_W
) (
    input  logic [VW-1:0]     val,
    output logic [BYTE_W-1:0] bcd
);

    logic [3:0] tens;
    logic [3:0] units;

    always_comb begin
        tens  = 4'(val / VW'(10));
        units = 4'(val % VW'(10));
        bcd   = {tens, units};
    end

endmodule

// File: rtl/cal_unpack.sv
module cal_unpack
    import cal_pkg::*;
(
    input  logic [NREG-1:0][BYTE_W-1:0] rb,
    output logic [NREG-1:0][BYTE_W-1:0] bin
);

    logic [NREG-1:0][BYTE_W-1:0] raw;

    for (genvar k = 0; k < NREG; k++) begin : g_dec
        always_comb begin
            raw[k] = BYTE_W'(rb[k][7:4]) * BYTE_W'(10) + BYTE_W'(rb[k][3:0]);
        end
    end

    always_comb begin
        bin = raw;
        if (raw[REG_YEAR] <= BYTE_W'(WRAP_LIMIT))
            bin[REG_YEAR] = raw[REG_YEAR] + BYTE_W'(100);
        bin[REG_MON] = raw[REG_MON] - BYTE_W'(1);
    end

endmodule

// File: rtl/cal_pack_top.sv
module cal_pack_top
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [11:0]       in_year,
    input  logic [3:0]        in_month,
    input  logic [4:0]        in_day,
    input  logic [4:0]        in_hour,
    input  logic [5:0]        in_min,
    input  logic [5:0]        in_sec,
    output logic              err_pulse,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [2:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              done_pulse,
    input  logic [7:0]        rb_year,
    input  logic [7:0]        rb_month,
    input  logic [7:0]        rb_day,
    input  logic [7:0]        rb_hour,
    input  logic [7:0]        rb_min,
    input  logic [7:0]        rb_sec,
    output logic [7:0]        out_year,
    output logic [7:0]        out_month,
    output logic [7:0]        out_day,
    output logic [7:0]        out_hour,
    output logic [7:0]        out_min,
    output logic [7:0]        out_sec
);

    pk_state_e                    state, nxt;
    logic [IDX_W-1:0]             idx, idx_nxt;
    logic [NREG-1:0][BYTE_W-1:0]  hold;
    logic [NREG-1:0][BYTE_W-1:0]  enc;
    logic [NREG-1:0][VAL_W-1:0]   slot_val;
    logic                         legal;
    logic [VAL_W-1:0]             yy;
    logic                         accept;
    logic                         last_hs;

    cal_check u_check (
        .year   (in_year),
        .month  (in_month),
        .day    (in_day),
        .hour   (in_hour),
        .minute (in_min),
        .second (in_sec),
        .legal  (legal),
        .yy     (yy)
    );

    // Slot k is the kth write; its register index is REG_YEAR - k.
    always_comb begin
        slot_val[0] = yy;
        slot_val[1] = VAL_W'(in_month);
        slot_val[2] = VAL_W'(in_day);
        slot_val[3] = VAL_W'(in_hour);
        slot_val[4] = VAL_W'(in_min);
        slot_val[5] = VAL_W'(in_sec);
    end

    for (genvar k = 0; k < NREG; k++) begin : g_enc
        bcd_enc u_enc (
            .val (slot_val[k]),
            .bcd (enc[k])
        );
    end

    cal_unpack u_unpack (
        .rb  ({rb_year, rb_month, rb_day, rb_hour, rb_min, rb_sec}),
        .bin ({out_year, out_month, out_day, out_hour, out_min, out_sec})
    );

    assign accept  = in_valid && in_ready;
    assign last_hs = wr_valid && wr_ready && (idx == IDX_W'(NREG - 1));

    // Next-state logic
    always_comb begin
        nxt     = state;
        idx_nxt = idx;
        unique case (state)
            ST_IDLE: begin
                if (accept && legal) begin
                    nxt     = ST_EMIT;
                    idx_nxt = '0;
                end
            end
            ST_EMIT: begin
                if (wr_ready) begin
                    if (idx == IDX_W'(NREG - 1))
                        nxt = ST_FIN;
                    else
                        idx_nxt = idx + IDX_W'(1);
                end
            end
            ST_FIN: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            hold  <= '0;
        end else begin
            state <= nxt;
            idx   <= idx_nxt;
            if (state == ST_IDLE && accept && legal)
                hold <= enc;
        end
    end

    // Outputs
    always_comb begin
        in_ready   = 1'b0;
        err_pulse  = 1'b0;
        wr_valid   = 1'b0;
        done_pulse = 1'b0;
        wr_addr    = ADDR_W'(REG_YEAR) - ADDR_W'(idx);
        wr_data    = hold[idx];
        unique case (state)
            ST_IDLE: begin
                in_ready  = 1'b1;
                err_pulse = in_valid && !legal;
            end
            ST_EMIT: wr_valid   = 1'b1;
            ST_FIN:  done_pulse = 1'b1;
            default: ;
        endcase
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || done_pulse) |-> !in_ready); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (!wr_valid && in_ready)); // R5
    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(last_hs && wr_addr == ADDR_W'(REG_SEC))); // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (!done_pulse && in_ready)); // R9
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[3:0] <= 4'd9 && wr_data[7:4] <= 4'd9)); // R6
    AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && (wr_valid || done_pulse))); // R5

endmodule

// File: tb/cal_pack_top_tb_top.sv
module cal_pack_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_year = '0;
    logic [3:0]  in_month = '0;
    logic [4:0]  in_day = '0;
    logic [4:0]  in_hour = '0;
    logic [5:0]  in_min = '0;
    logic [5:0]  in_sec = '0;
    logic        err_pulse, wr_valid, done_pulse;
    logic        wr_ready = 1'b0;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rb_year = '0, rb_month = '0, rb_day = '0, rb_hour = '0, rb_min = '0, rb_sec = '0;
    logic [7:0]  out_year, out_month, out_day, out_hour, out_min, out_sec;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cal_pack_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_year(in_year), .in_month(in_month), .in_day(in_day),
        .in_hour(in_hour), .in_min(in_min), .in_sec(in_sec),
        .err_pulse(err_pulse), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .done_pulse(done_pulse),
        .rb_year(rb_year), .rb_month(rb_month), .rb_day(rb_day),
        .rb_hour(rb_hour), .rb_min(rb_min), .rb_sec(rb_sec),
        .out_year(out_year), .out_month(out_month), .out_day(out_day),
        .out_hour(out_hour), .out_min(out_min), .out_sec(out_sec)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mdays(input int y, input int m);
        bit lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        case (m)
            2: return lp ? 29 : 28;
            4, 6, 9, 11: return 30;
            1, 3, 5, 7, 8, 10, 12: return 31;
            default: return 0;
        endcase
    endfunction

    function automatic bit ok_set(input int y, m, d, h, mi, s);
        return (y >= 1970) && (y <= 2069) && (m >= 1) && (m <= 12) && (d >= 1)
            && (d <= mdays(y, m)) && (h < 24) && (mi < 60) && (s < 60);
    endfunction

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    task automatic send(input int y, m, d, h, mi, s);
        int exp_d[6];
        int idx;
        bit lg;
        lg = ok_set(y, m, d, h, mi, s);
        exp_d[0] = to_bcd(y >= 2000 ? y - 2000 : y - 1900); // R7
        exp_d[1] = to_bcd(m);
        exp_d[2] = to_bcd(d);
        exp_d[3] = to_bcd(h);
        exp_d[4] = to_bcd(mi);
        exp_d[5] = to_bcd(s);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_year = 12'(y); in_month = 4'(m); in_day = 5'(d);
        in_hour = 5'(h); in_min = 6'(mi); in_sec = 6'(s);
        #1;
        check("R2/R3/R4/R5 err_pulse", int'(err_pulse), int'(!lg));
        @(negedge clk);
        in_valid = 1'b0;
        if (!lg) begin
            #1;
            check("R5 no write after reject", int'(wr_valid), 0);
            check("R5 in_ready after reject", int'(in_ready), 1);
        end else begin
            idx = 0;
            while (idx < 6) begin
                wr_ready = ($urandom % 3) != 0;
                #1;
                check("R8 in_ready low while busy", int'(in_ready), 0);
                check("R6 wr_valid while emitting", int'(wr_valid), 1);
                check("R6 wr_addr order", int'(wr_addr), 5 - idx);
                check("R6/R7 wr_data", int'(wr_data), exp_d[idx]);
                if (wr_ready) idx++;
                @(negedge clk);
            end
            wr_ready = 1'b0;
            #1;
            check("R9 done_pulse", int'(done_pulse), 1);
            check("R9 no write at done", int'(wr_valid), 0);
            check("R8 in_ready low at done", int'(in_ready), 0);
            @(negedge clk);
            #1;
            check("R9 done one cycle", int'(done_pulse), 0);
            check("R9 in_ready back", int'(in_ready), 1);
        end
    endtask

    task automatic readback(input int y, m, d, h, mi, s);
        int yv;
        rb_year = 8'(to_bcd(y)); rb_month = 8'(to_bcd(m)); rb_day = 8'(to_bcd(d));
        rb_hour = 8'(to_bcd(h)); rb_min = 8'(to_bcd(mi)); rb_sec = 8'(to_bcd(s));
        #1;
        yv = from_bcd(int'(rb_year));
        check("R11 out_year", int'(out_year), (yv <= 69) ? yv + 100 : yv);
        check("R11 out_month", int'(out_month), (from_bcd(int'(rb_month)) - 1) & 255);
        check("R10 out_day", int'(out_day), d);
        check("R10 out_hour", int'(out_hour), h);
        check("R10 out_min", int'(out_min), mi);
        check("R10 out_sec", int'(out_sec), s);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset in_ready", int'(in_ready), 1);
        check("R1 reset wr_valid", int'(wr_valid), 0);
        check("R1 reset done_pulse", int'(done_pulse), 0);
        check("R1 reset err_pulse", int'(err_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        send(1969, 6, 1, 0, 0, 0);    // R2
        send(1970, 1, 1, 0, 0, 0);    // R2
        send(2069, 12, 31, 23, 59, 59); // R2
        send(2070, 1, 1, 0, 0, 0);    // R2
        send(2000, 2, 29, 12, 0, 0);  // R3
        send(2024, 2, 29, 1, 2, 3);   // R3
        send(2023, 2, 29, 1, 2, 3);   // R3
        send(2023, 4, 31, 0, 0, 0);   // R3
        send(2023, 0, 10, 0, 0, 0);   // R3
        send(2023, 13, 10, 0, 0, 0);  // R3
        send(2023, 5, 0, 0, 0, 0);    // R3
        send(2023, 5, 5, 24, 0, 0);   // R4
        send(2023, 5, 5, 0, 60, 0);   // R4
        send(2023, 5, 5, 0, 0, 60);   // R4
        send(1999, 12, 31, 23, 59, 59); // R7

        readback(69, 1, 1, 0, 0, 0);  // R11
        readback(70, 12, 31, 23, 59, 59); // R11
        readback(0, 0, 15, 9, 30, 45); // R11

        // Constrained random
        for (int t = 0; t < 300; t++) begin
            int y, m, d, h, mi, s;
            if ($urandom % 2) begin
                y = 1970 + int'($urandom % 100); m = 1 + int'($urandom % 12);
                d = 1 + int'($urandom % 31); h = int'($urandom % 24);
                mi = int'($urandom % 60); s = int'($urandom % 60);
            end else begin
                y = 1960 + int'($urandom % 120); m = int'($urandom % 14);
                d = int'($urandom % 32); h = int'($urandom % 26);
                mi = int'($urandom % 62); s = int'($urandom % 62);
            end
            send(y, m, d, h, mi, s);
        end
        for (int t = 0; t < 40; t++) begin
            readback(int'($urandom % 100), int'($urandom % 13), int'($urandom % 32),
                     int'($urandom % 24), int'($urandom % 60), int'($urandom % 60));
        end
        finish_run();
    end

endmodule